// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects the interrupt events of a USB device controller into one interrupt line. The events fall into five groups: link speed change, USB2 bus events (suspend, resume, reset), USB3 link-state events (hot reset, warm reset, VBUS rise, VBUS fall, entering U3, leaving U3), endpoint-0 buffer events and queue events. Each group has a sticky status register and an enable register. A group's pending bits are cleared by writing ones to its status. Its enable is changed only through a dedicated set address and a dedicated clear address.

A second level holds one summary bit per group. The bit is high when that group has a pending bit that is also enabled. This level-1 status is read-only. It has its own enable register, again changed through set and clear addresses. The output `irq_o` is the registered OR of the enabled level-1 bits. Software reads the level-1 status to find the group, reads that group's status, and then writes ones to clear what it has handled.

All registers sit on a simple word-addressed bus. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every group status, every group enable, the level-1 enable and `irq_o` are zero.
- R2: An event input bit that is high at a clock edge sets the matching group status bit. The bit stays set after the event drops, whether or not that bit is enabled.
- R3: Writing to a group status address clears each status bit whose write-data bit is 1 and leaves the others unchanged. Writing all ones clears every pending bit.
- R4: When an event and a clear write hit the same status bit on the same edge, the event wins and the bit stays set.
- R5: Writing to an enable set address (group or level-1) sets each enable bit whose data bit is 1. Zero data bits leave their enable bits unchanged.
- R6: Writing to an enable clear address clears each enable bit whose data bit is 1. Writing all ones disables everything in that register.
- R7: A write to an enable read address, or to the level-1 status address, changes no register.
- R8: Level-1 status bit g is the OR over group g of (status AND enable). The bit positions are 0 = link, 1 = USB2, 2 = USB3, 3 = EP0 buffer, 4 = queue.
- R9: `irq_o` equals the OR of (level-1 status AND level-1 enable), delayed by exactly one clock.
- R10: Source bit positions are as follows. Link: bit 0 is speed change. USB2: bit 0 suspend, bit 1 resume, bit 2 reset. USB3: bit 0 hot reset, bit 1 warm reset, bit 2 VBUS rise, bit 3 VBUS fall, bit 4 enter U3, bit 5 exit U3. The buffer and queue groups are BUF_W and QUE_W bits wide from bit 0. Bits above a group's width read as zero and cannot be set.
- R11: The register address is the word address. Group g uses addresses 4g+0 (status, write-one-to-clear), 4g+1 (enable, read), 4g+2 (enable set) and 4g+3 (enable clear). Level 1 uses 20 (status), 21 (enable read), 22 (enable set) and 23 (enable clear). Set and clear addresses and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| ev_link | input | 1 | Link speed-change event |
| ev_usb2 | input | 3 | USB2 bus events |
| ev_usb3 | input | 6 | USB3 link-state events |
| ev_buf | input | BUF_W | EP0 buffer events |
| ev_que | input | QUE_W | Queue events |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
A status bit that is lost or stuck shows up at once. The group status read shows it in the cycle after the event edge, and the level-1 status read shows it as soon as the matching enable is set. A wrong enable or a wrong level-1 summary appears on `irq_o` exactly one clock later, so the tests check the output both on the edge before the change and on the edge after it. They also cover a clear write that collides with an event, and writes to read-only and enable-read addresses. Each of these cases is followed by a read-back, so that a write that modified state it must not touch is caught before the next stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_GRP = 5;

    // group index equals its level-1 bit position
    localparam int GRP_LINK = 0;
    localparam int GRP_USB2 = 1;
    localparam int GRP_USB3 = 2;
    localparam int GRP_BUF  = 3;
    localparam int GRP_QUE  = 4;

    localparam int USB2_SRC_W = 3;
    localparam int USB3_SRC_W = 6;
    localparam int LINK_SRC_W = 1;

    // register offset inside a four-word window
    localparam logic [1:0] OFS_STAT = 2'd0;
    localparam logic [1:0] OFS_EN   = 2'd1;
    localparam logic [1:0] OFS_SET  = 2'd2;
    localparam logic [1:0] OFS_CLR  = 2'd3;

    typedef struct packed {
        logic [NUM_GRP-1:0] l1_en;
        logic               irq;
    } top_state_t;

endpackage

// File: rtl/irq_agg_dec.sv
module irq_agg_dec
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output logic [NUM_GRP-1:0] grp_w1c,
    output logic [NUM_GRP-1:0] grp_set,
    output logic [NUM_GRP-1:0] grp_clr,
    output logic               l1_set,
    output logic               l1_clr,
    output logic               grp_hit,
    output logic [ADDR_W-3:0]  grp_idx,
    output logic               l1_hit,
    output logic [1:0]         ofs
);

    always_comb begin
        grp_idx = addr[ADDR_W-1:2];
        ofs     = addr[1:0];
        grp_hit = int'(grp_idx) < NUM_GRP;
        l1_hit  = int'(grp_idx) == NUM_GRP;
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_w1c[g] = wr && grp_hit && (int'(grp_idx) == g) && (ofs == OFS_STAT);
            grp_set[g] = wr && grp_hit && (int'(grp_idx) == g) && (ofs == OFS_SET);
            grp_clr[g] = wr && grp_hit && (int'(grp_idx) == g) && (ofs == OFS_CLR);
        end
        l1_set = wr && l1_hit && (ofs == OFS_SET);
        l1_clr = wr && l1_hit && (ofs == OFS_CLR);
    end

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group #(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev,
    input  logic [DATA_W-1:0] wdata,
    input  logic              w1c,
    input  logic              en_set,
    input  logic              en_clr,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] en_o,
    output logic              sum_o
);

    localparam logic [DATA_W-1:0] IMPL = DATA_W'((65'd1 << SRC_W) - 65'd1);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] en;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (w1c) begin
            st_d.stat = st_q.stat & ~wdata;
        end
        // a new event overrides a clear in the same cycle
        st_d.stat = (st_d.stat | ev) & IMPL;
        if (en_set) begin
            st_d.en = st_q.en | wdata;
        end
        if (en_clr) begin
            st_d.en = st_q.en & ~wdata;
        end
        st_d.en = st_d.en & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign sum_o  = |(st_q.stat & st_q.en);

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int BUF_W  = 2,
    parameter int QUE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_link,
    input  logic [2:0]        ev_usb2,
    input  logic [5:0]        ev_usb3,
    input  logic [BUF_W-1:0]  ev_buf,
    input  logic [QUE_W-1:0]  ev_que,
    output logic              irq_o
);

    localparam int GRP_SRC_W [NUM_GRP] = '{LINK_SRC_W, USB2_SRC_W, USB3_SRC_W, BUF_W, QUE_W};

    logic [NUM_GRP-1:0][DATA_W-1:0] ev_pad;
    logic [NUM_GRP-1:0][DATA_W-1:0] grp_stat;
    logic [NUM_GRP-1:0][DATA_W-1:0] grp_en;
    logic [NUM_GRP-1:0]             grp_sum;

    logic [NUM_GRP-1:0] dec_w1c, dec_set, dec_clr;
    logic               dec_l1_set, dec_l1_clr;
    logic               dec_grp_hit, dec_l1_hit;
    logic [ADDR_W-3:0]  dec_grp_idx;
    logic [1:0]         dec_ofs;

    top_state_t         top_d, top_q;
    logic [NUM_GRP-1:0] l1_en_q;

    always_comb begin
        ev_pad           = '0;
        ev_pad[GRP_LINK] = DATA_W'(ev_link);
        ev_pad[GRP_USB2] = DATA_W'(ev_usb2);
        ev_pad[GRP_USB3] = DATA_W'(ev_usb3);
        ev_pad[GRP_BUF]  = DATA_W'(ev_buf);
        ev_pad[GRP_QUE]  = DATA_W'(ev_que);
    end

    irq_agg_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .grp_w1c (dec_w1c),
        .grp_set (dec_set),
        .grp_clr (dec_clr),
        .l1_set  (dec_l1_set),
        .l1_clr  (dec_l1_clr),
        .grp_hit (dec_grp_hit),
        .grp_idx (dec_grp_idx),
        .l1_hit  (dec_l1_hit),
        .ofs     (dec_ofs)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_agg_group #(
            .DATA_W (DATA_W),
            .SRC_W  (GRP_SRC_W[g])
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev_pad[g]),
            .wdata  (bus_wdata),
            .w1c    (dec_w1c[g]),
            .en_set (dec_set[g]),
            .en_clr (dec_clr[g]),
            .stat_o (grp_stat[g]),
            .en_o   (grp_en[g]),
            .sum_o  (grp_sum[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (dec_l1_set) begin
            top_d.l1_en = top_q.l1_en | bus_wdata[NUM_GRP-1:0];
        end
        if (dec_l1_clr) begin
            top_d.l1_en = top_q.l1_en & ~bus_wdata[NUM_GRP-1:0];
        end
        top_d.irq = |(grp_sum & top_q.l1_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign l1_en_q = top_q.l1_en;
    assign irq_o   = top_q.irq;

    always_comb begin
        bus_rdata = '0;
        if (dec_grp_hit) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (int'(dec_grp_idx) == g) begin
                    if (dec_ofs == OFS_STAT) bus_rdata = grp_stat[g];
                    if (dec_ofs == OFS_EN)   bus_rdata = grp_en[g];
                end
            end
        end else if (dec_l1_hit) begin
            if (dec_ofs == OFS_STAT) bus_rdata = DATA_W'(grp_sum);
            if (dec_ofs == OFS_EN)   bus_rdata = DATA_W'(l1_en_q);
        end
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_wr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic [NUM_GRP-1:0][DATA_W-1:0] ev_pad,
    input logic [NUM_GRP-1:0][DATA_W-1:0] grp_stat,
    input logic [NUM_GRP-1:0][DATA_W-1:0] grp_en,
    input logic [NUM_GRP-1:0]             l1_en_q,
    input logic                           irq_o
);

    localparam logic [ADDR_W-1:0] L1_SET_A = ADDR_W'(NUM_GRP * 4 + 2);
    localparam logic [ADDR_W-1:0] L1_CLR_A = ADDR_W'(NUM_GRP * 4 + 3);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4 * g);
        localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(4 * g + 2);
        localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(4 * g + 3);

        AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_pad[g] != '0) |=> ((grp_stat[g] & $past(ev_pad[g])) == $past(ev_pad[g]))); // R2

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == STAT_A && ev_pad[g] == '0)
            |=> ((grp_stat[g] & $past(bus_wdata)) == '0)); // R3

        AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SET_A)
            |=> ((grp_en[g] & $past(grp_en[g])) == $past(grp_en[g]))); // R5

        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == CLR_A)
            |=> ((grp_en[g] & $past(bus_wdata)) == '0)); // R6

        AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_wr && (bus_addr == SET_A || bus_addr == CLR_A))
            |=> $stable(grp_en[g])); // R7
    end

    AST_L1_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == L1_SET_A || bus_addr == L1_CLR_A))
        |=> $stable(l1_en_q)); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_en_q == '0) |=> !irq_o); // R9

endmodule

bind irq_agg_top irq_agg_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ev_pad    (ev_pad),
    .grp_stat  (grp_stat),
    .grp_en    (grp_en),
    .l1_en_q   (l1_en_q),
    .irq_o     (irq_o)
);

// File: tb/irq_agg_top_tb.sv
`timescale 1ns/1ps
module irq_agg_top_tb;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int BUF_W  = 2;
    localparam int QUE_W  = 8;

    localparam logic [ADDR_W-1:0] A_LINK = 5'd0;
    localparam logic [ADDR_W-1:0] A_USB2 = 5'd4;
    localparam logic [ADDR_W-1:0] A_USB3 = 5'd8;
    localparam logic [ADDR_W-1:0] A_BUF  = 5'd12;
    localparam logic [ADDR_W-1:0] A_QUE  = 5'd16;
    localparam logic [ADDR_W-1:0] A_L1   = 5'd20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              ev_link = 1'b0;
    logic [2:0]        ev_usb2 = '0;
    logic [5:0]        ev_usb3 = '0;
    logic [BUF_W-1:0]  ev_buf = '0;
    logic [QUE_W-1:0]  ev_que = '0;
    logic              irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_agg_top #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BUF_W  (BUF_W),
        .QUE_W  (QUE_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_link   (ev_link),
        .ev_usb2   (ev_usb2),
        .ev_usb3   (ev_usb3),
        .ev_buf    (ev_buf),
        .ev_que    (ev_que),
        .irq_o     (irq_o)
    );

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // all event vectors held high across exactly one rising edge
    task automatic pulse(logic l, logic [2:0] u2, logic [5:0] u3, logic [BUF_W-1:0] b, logic [QUE_W-1:0] q);
        @(negedge clk);
        ev_link = l; ev_usb2 = u2; ev_usb3 = u3; ev_buf = b; ev_que = q;
        @(posedge clk);
        @(negedge clk);
        ev_link = 1'b0; ev_usb2 = '0; ev_usb3 = '0; ev_buf = '0; ev_que = '0;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        for (int a = 0; a < 24; a++) begin
            rd(ADDR_W'(a), v);
            check($sformatf("R1 reset reg %0d", a), v, '0);
        end
        check("R1 reset irq", DATA_W'(irq_o), '0);
    endtask

    task automatic t_latch();
        logic [DATA_W-1:0] v;
        pulse(1'b0, 3'b000, 6'b100101, '0, '0);
        rd(A_USB3, v);
        check("R2 R10 usb3 status latched while disabled", v, 32'h25);
        rd(A_L1, v);
        check("R8 level-1 masked by group enable", v, '0);
        check("R9 irq quiet", DATA_W'(irq_o), '0);
    endtask

    task automatic t_w1c();
        logic [DATA_W-1:0] v;
        wr(A_USB3, 32'h05);
        rd(A_USB3, v);
        check("R3 partial clear", v, 32'h20);
        wr(A_USB3, '1);
        rd(A_USB3, v);
        check("R3 clear all", v, '0);
    endtask

    task automatic t_enable();
        logic [DATA_W-1:0] v;
        wr(A_USB2 + 5'd2, 32'h3);
        rd(A_USB2 + 5'd1, v);
        check("R5 set", v, 32'h3);
        wr(A_USB2 + 5'd2, 32'h4);
        rd(A_USB2 + 5'd1, v);
        check("R5 set keeps others", v, 32'h7);
        wr(A_USB2 + 5'd3, 32'h1);
        rd(A_USB2 + 5'd1, v);
        check("R6 clear one", v, 32'h6);
        wr(A_USB2 + 5'd1, '0);
        rd(A_USB2 + 5'd1, v);
        check("R7 direct enable write ignored", v, 32'h6);
        rd(A_USB2 + 5'd2, v);
        check("R11 set address reads zero", v, '0);
        wr(A_USB2 + 5'd3, '1);
        rd(A_USB2 + 5'd1, v);
        check("R6 clear all", v, '0);
        wr(A_USB2 + 5'd2, '1);
        rd(A_USB2 + 5'd1, v);
        check("R10 unimplemented enable bits", v, 32'h7);
        wr(A_USB2 + 5'd3, '1);
        pulse(1'b0, 3'b111, '0, '0, '0);
        rd(A_USB2, v);
        check("R10 usb2 width", v, 32'h7);
        wr(A_USB2, '1);
    endtask

    task automatic t_level1();
        logic [DATA_W-1:0] v;
        wr(A_LINK + 5'd2, 32'h1);
        pulse(1'b1, '0, '0, '0, '0);
        rd(A_L1, v);
        check("R8 link summary bit 0", v, 32'h1);
        check("R9 no irq with level-1 disabled", DATA_W'(irq_o), '0);
        wr(A_L1 + 5'd2, 32'h1);
        rd(A_L1 + 5'd1, v);
        check("R5 level-1 enable set", v, 32'h1);
        check("R9 irq not yet (one-cycle delay)", DATA_W'(irq_o), '0);
        @(negedge clk);
        check("R9 irq asserted", DATA_W'(irq_o), 32'h1);
        wr(A_L1, '1);
        rd(A_L1, v);
        check("R7 level-1 status write ignored", v, 32'h1);
        wr(A_LINK, 32'h1);
        rd(A_L1, v);
        check("R3 R8 summary drops", v, '0);
        check("R9 irq still high one cycle", DATA_W'(irq_o), 32'h1);
        @(negedge clk);
        check("R9 irq dropped", DATA_W'(irq_o), '0);
    endtask

    task automatic t_collide();
        logic [DATA_W-1:0] v;
        pulse(1'b0, 3'b011, '0, '0, '0);
        @(negedge clk);
        bus_addr = A_USB2; bus_wdata = 32'h3; bus_wr = 1'b1;
        ev_usb2 = 3'b010;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; ev_usb2 = '0;
        rd(A_USB2, v);
        check("R4 event beats clear", v, 32'h2);
        wr(A_USB2, '1);
    endtask

    task automatic t_groups();
        logic [DATA_W-1:0] v;
        wr(A_BUF + 5'd2, '1);
        wr(A_QUE + 5'd2, 32'h80);
        pulse(1'b0, '0, '0, 2'b10, 8'h81);
        rd(A_BUF, v);
        check("R10 buffer status", v, 32'h2);
        rd(A_QUE, v);
        check("R10 queue status", v, 32'h81);
        rd(A_L1, v);
        check("R8 buffer and queue summaries", v, 32'h18);
        wr(A_L1 + 5'd2, 32'h10);
        @(negedge clk);
        check("R9 irq from queue", DATA_W'(irq_o), 32'h1);
        wr(A_L1 + 5'd3, '1);
        rd(A_L1 + 5'd1, v);
        check("R6 level-1 clear all", v, '0);
        @(negedge clk);
        check("R9 irq off after disable", DATA_W'(irq_o), '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_w1c();
        t_enable();
        t_level1();
        t_collide();
        t_groups();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule